// File: doc/BRIEF.md
# Extended-Arithmetic Micro-Operation Sequencer

This block accepts 12-bit instruction words from the processor's issue logic and, for words of the extended-arithmetic group, runs the micro-operations they encode. These operations act on the accumulator, the multiplier-quotient register, the link bit and a 5-bit step counter. One word may combine several micro-operation bits. The bits never act at the same moment. They run as a clear phase, then a register-transfer phase, then one selected operation.

Most selected operations need a second word, the operand that follows the instruction in memory. The sequencer asks for it on a request/valid fetch port and holds the request until the word arrives. Multiply, divide, normalize and the three shifts go to an external arithmetic and shift unit. The sequencer sends a one-cycle start pulse carrying the operation code, operand and shift count. It then takes the unit's results when the unit signals done. The processor may write the accumulator and link directly while the sequencer is idle.

Bit numbering in the requirements follows the instruction-set convention: bit 0 is the most significant bit of a 12-bit word (`instr_word[11]`) and bit 11 is the least significant (`instr_word[0]`).

Top module: `eae_sequencer`

## Requirements
- R1: After reset, `ac`, `mq`, `link` and `sc` are zero and `busy`, `seq_done`, `opnd_req` and `unit_start` are low.
- R2: A word is accepted only when bits 0-3 are all ones (`instr_word[11:8]` = 4'b1111, octal 74xx) and bit 11 is one. Any other word causes no register change, no fetch and no done pulse.
- R3: Bit 4 (`instr_word[7]`) clears the accumulator before every other micro-operation of the same word, and leaves `mq` and `link` unchanged.
- R4: Bit 5 (`instr_word[6]`) ORs `mq` into `ac` and leaves `mq` unchanged. Bit 6 (`instr_word[5]`) ORs `sc` into accumulator bits 7-11 (`ac[4:0]`).
- R5: Bit 7 (`instr_word[4]`) copies the accumulator into `mq` and clears the accumulator. When bit 5 is also set, the two registers swap.
- R6: All transfers of phase 2 see the accumulator after the phase-1 clear. The selected phase-3 operation sees the registers after phase 2.
- R7: Bits 8-10 (`instr_word[3:1]`) select the phase-3 operation: 1 load SC, 2 multiply, 3 divide, 4 normalize, 5 shift left, 6 arithmetic shift right, 7 logical shift right. When they are zero, phase 3 is skipped, with no fetch and no unit start.
- R8: Every phase-3 operation except normalize raises `opnd_req` and holds it until a cycle with `opnd_valid` high. It makes exactly one fetch per instruction.
- R9: Load SC writes the ones' complement of operand bits 7-11 (`opnd_data[4:0]`) into `sc`. It does not start the unit.
- R10: Codes 2-7 give exactly one one-cycle `unit_start` with `unit_cmd` equal to the code, `unit_arg` equal to the fetched operand and `unit_count` equal to its low 5 bits. On `unit_done` the results are loaded into `ac`, `mq` and `link`. `sc` takes the unit's value only for normalize.
- R11: Normalize (code 4) starts the unit without fetching an operand.
- R12: Each accepted word ends with a one-cycle `seq_done`. `busy` is high from acceptance until the cycle after that pulse, and words presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered this cycle |
| instr_word | input | DATA_W | Instruction word |
| busy | output | 1 | Sequencer is working on an accepted word |
| seq_done | output | 1 | One-cycle pulse at the end of an instruction |
| cpu_ac_we | input | 1 | Processor writes the accumulator (idle only) |
| cpu_ac_wdata | input | DATA_W | Accumulator write value |
| cpu_link_we | input | 1 | Processor writes the link (idle only) |
| cpu_link_wdata | input | 1 | Link write value |
| opnd_req | output | 1 | Operand word requested |
| opnd_valid | input | 1 | Operand word present on `opnd_data` |
| opnd_data | input | DATA_W | Operand word |
| unit_start | output | 1 | One-cycle start to the arithmetic and shift unit |
| unit_cmd | output | 3 | Phase-3 operation code |
| unit_arg | output | DATA_W | Fetched operand |
| unit_count | output | SC_W | Low operand bits (shift count) |
| unit_done | input | 1 | Unit results valid |
| unit_res_ac | input | DATA_W | Result for the accumulator |
| unit_res_mq | input | DATA_W | Result for MQ |
| unit_res_link | input | 1 | Result for the link |
| unit_res_sc | input | SC_W | Step count result (normalize) |
| ac | output | DATA_W | Accumulator |
| mq | output | DATA_W | Multiplier-quotient register |
| link | output | 1 | Link bit |
| sc | output | SC_W | Step counter |

## Verification
The bench builds the block with DATA_W = 12, SC_W = 5 and SPLIT_PHASES = 1. This gives the clear phase its own cycle, so the check that `mq` and `link` hold through that cycle is active. The bench's operand source uses several response delays, and its unit model computes a real product for multiply and recognisable values for the other codes. This makes phase ordering, swap, operand latching and the narrow SC update visible at the ports. Directed cases cover reset, non-group words and a word offered during a long unit operation.

// File: rtl/eae_seq_pkg.sv
package eae_seq_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_SCL  = 3'd1,
      OP_MUL  = 3'd2,
      OP_DIV  = 3'd3,
      OP_NRM  = 3'd4,
      OP_SHL  = 3'd5,
      OP_ASR  = 3'd6,
      OP_LSR  = 3'd7
   } eae_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLR,
      ST_XFER,
      ST_FETCH,
      ST_START,
      ST_WAIT,
      ST_FIN
   } eae_state_e;

   typedef struct packed {
      logic    clr_ac;
      logic    or_mq;
      logic    or_sc;
      logic    ld_mq;
      eae_op_e op;
   } eae_micro_t;

endpackage

// File: rtl/eae_decode.sv
module eae_decode
   import eae_seq_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] word,
   output logic              is_group,
   output eae_micro_t        micro
);

   // instruction-set bit n sits at vector index DATA_W-1-n
   localparam int GRP_HI  = DATA_W - 1;
   localparam int GRP_LO  = DATA_W - 4;
   localparam int IX_CLR  = DATA_W - 5;
   localparam int IX_ORMQ = DATA_W - 6;
   localparam int IX_ORSC = DATA_W - 7;
   localparam int IX_LDMQ = DATA_W - 8;

   always_comb begin
      is_group     = (&word[GRP_HI:GRP_LO]) & word[0];
      micro.clr_ac = word[IX_CLR];
      micro.or_mq  = word[IX_ORMQ];
      micro.or_sc  = word[IX_ORSC];
      micro.ld_mq  = word[IX_LDMQ];
      micro.op     = eae_op_e'(word[3:1]);
   end

endmodule

// File: rtl/eae_phase_fsm.sv
module eae_phase_fsm
   import eae_seq_pkg::*;
#(
   parameter bit SPLIT_PHASES = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  eae_op_e    op,
   input  logic       opnd_valid,
   input  logic       unit_done,
   output eae_state_e state,
   output logic       opnd_req,
   output logic       unit_start,
   output logic       seq_done,
   output logic       busy
);

   eae_state_e state_d;
   eae_state_e first_st;

   generate
      if (SPLIT_PHASES) begin : g_split
         assign first_st = ST_CLR;
      end else begin : g_fused
         assign first_st = ST_XFER;
      end
   endgenerate

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE:  if (accept) state_d = first_st;
         ST_CLR:   state_d = ST_XFER;
         ST_XFER: begin
            if (op == OP_NONE)     state_d = ST_FIN;
            else if (op == OP_NRM) state_d = ST_START;
            else                   state_d = ST_FETCH;
         end
         ST_FETCH: if (opnd_valid) state_d = (op == OP_SCL) ? ST_FIN : ST_START;
         ST_START: state_d = ST_WAIT;
         ST_WAIT:  if (unit_done) state_d = ST_FIN;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end

   assign opnd_req   = (state == ST_FETCH);
   assign unit_start = (state == ST_START);
   assign seq_done   = (state == ST_FIN);
   assign busy       = (state != ST_IDLE);

   p_noop_nofetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_req |-> (op != OP_NONE));
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_req && !opnd_valid) |=> opnd_req);
   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unit_start |=> !unit_start);
   p_nrm_nofetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_req |-> (op != OP_NRM));
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> (!seq_done && !busy));
   p_done_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> busy);

endmodule

// File: rtl/eae_regfile.sv
module eae_regfile
   import eae_seq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int SC_W         = 5,
   parameter bit SPLIT_PHASES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  eae_state_e        state,
   input  eae_micro_t        micro,
   input  logic              cpu_ac_we,
   input  logic [DATA_W-1:0] cpu_ac_wdata,
   input  logic              cpu_link_we,
   input  logic              cpu_link_wdata,
   input  logic              opnd_valid,
   input  logic [DATA_W-1:0] opnd_data,
   input  logic              unit_done,
   input  logic [DATA_W-1:0] unit_res_ac,
   input  logic [DATA_W-1:0] unit_res_mq,
   input  logic              unit_res_link,
   input  logic [SC_W-1:0]   unit_res_sc,
   output logic [DATA_W-1:0] ac,
   output logic [DATA_W-1:0] mq,
   output logic              link,
   output logic [SC_W-1:0]   sc,
   output logic [DATA_W-1:0] opnd_q
);

   localparam int PAD_W = DATA_W - SC_W;

   logic [DATA_W-1:0] xfer_base;
   logic [DATA_W-1:0] sc_ext;
   logic [DATA_W-1:0] ac_xfer;

   // With a separate clear cycle the accumulator is already cleared when
   // the transfer phase runs; fused, the clear is folded in here.
   generate
      if (SPLIT_PHASES) begin : g_split
         assign xfer_base = ac;
      end else begin : g_fused
         assign xfer_base = micro.clr_ac ? '0 : ac;
      end
   endgenerate

   assign sc_ext  = {{PAD_W{1'b0}}, sc};
   assign ac_xfer = (micro.ld_mq ? '0 : xfer_base)
                  | (micro.or_mq ? mq : '0)
                  | (micro.or_sc ? sc_ext : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac     <= '0;
         mq     <= '0;
         link   <= 1'b0;
         sc     <= '0;
         opnd_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cpu_ac_we)   ac   <= cpu_ac_wdata;
               if (cpu_link_we) link <= cpu_link_wdata;
            end
            ST_CLR: begin
               if (micro.clr_ac) ac <= '0;
            end
            ST_XFER: begin
               if (micro.ld_mq) mq <= xfer_base;
               ac <= ac_xfer;
            end
            ST_FETCH: begin
               if (opnd_valid) begin
                  opnd_q <= opnd_data;
                  if (micro.op == OP_SCL) sc <= ~opnd_data[SC_W-1:0];
               end
            end
            ST_WAIT: begin
               if (unit_done) begin
                  ac   <= unit_res_ac;
                  mq   <= unit_res_mq;
                  link <= unit_res_link;
                  if (micro.op == OP_NRM) sc <= unit_res_sc;
               end
            end
            default: ;
         endcase
      end
   end

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> ($stable(mq) && $stable(sc)));
   p_clr_keeps_mq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CLR) |=> ($stable(mq) && $stable(link)));
   p_orsc_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER && micro.or_sc) |=> ((ac[SC_W-1:0] & $past(sc)) == $past(sc)));
   p_sc_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && micro.op != OP_NRM) |=> $stable(sc));

endmodule

// File: rtl/eae_sequencer.sv
module eae_sequencer
   import eae_seq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int SC_W         = 5,
   parameter bit SPLIT_PHASES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [DATA_W-1:0] instr_word,
   output logic              busy,
   output logic              seq_done,
   input  logic              cpu_ac_we,
   input  logic [DATA_W-1:0] cpu_ac_wdata,
   input  logic              cpu_link_we,
   input  logic              cpu_link_wdata,
   output logic              opnd_req,
   input  logic              opnd_valid,
   input  logic [DATA_W-1:0] opnd_data,
   output logic              unit_start,
   output logic [2:0]        unit_cmd,
   output logic [DATA_W-1:0] unit_arg,
   output logic [SC_W-1:0]   unit_count,
   input  logic              unit_done,
   input  logic [DATA_W-1:0] unit_res_ac,
   input  logic [DATA_W-1:0] unit_res_mq,
   input  logic              unit_res_link,
   input  logic [SC_W-1:0]   unit_res_sc,
   output logic [DATA_W-1:0] ac,
   output logic [DATA_W-1:0] mq,
   output logic              link,
   output logic [SC_W-1:0]   sc
);

   generate
      if (DATA_W != 12) begin : g_bad_width
         $error("eae_sequencer: the micro-operation field layout needs DATA_W == 12");
      end
      if (SC_W < 1 || SC_W >= DATA_W) begin : g_bad_sc
         $error("eae_sequencer: SC_W must lie between 1 and DATA_W-1");
      end
   endgenerate

   eae_micro_t micro_dec;
   eae_micro_t micro_q;
   eae_state_e state;
   logic       is_group;
   logic       accept;
   logic [DATA_W-1:0] opnd_q;

   eae_decode #(.DATA_W(DATA_W)) u_dec (
      .word     (instr_word),
      .is_group (is_group),
      .micro    (micro_dec)
   );

   assign accept = instr_valid && is_group && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      micro_q <= '0;
      else if (accept) micro_q <= micro_dec;
   end

   eae_phase_fsm #(.SPLIT_PHASES(SPLIT_PHASES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .op         (micro_q.op),
      .opnd_valid (opnd_valid),
      .unit_done  (unit_done),
      .state      (state),
      .opnd_req   (opnd_req),
      .unit_start (unit_start),
      .seq_done   (seq_done),
      .busy       (busy)
   );

   eae_regfile #(
      .DATA_W       (DATA_W),
      .SC_W         (SC_W),
      .SPLIT_PHASES (SPLIT_PHASES)
   ) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .state          (state),
      .micro          (micro_q),
      .cpu_ac_we      (cpu_ac_we),
      .cpu_ac_wdata   (cpu_ac_wdata),
      .cpu_link_we    (cpu_link_we),
      .cpu_link_wdata (cpu_link_wdata),
      .opnd_valid     (opnd_valid),
      .opnd_data      (opnd_data),
      .unit_done      (unit_done),
      .unit_res_ac    (unit_res_ac),
      .unit_res_mq    (unit_res_mq),
      .unit_res_link  (unit_res_link),
      .unit_res_sc    (unit_res_sc),
      .ac             (ac),
      .mq             (mq),
      .link           (link),
      .sc             (sc),
      .opnd_q         (opnd_q)
   );

   assign unit_cmd   = micro_q.op;
   assign unit_arg   = opnd_q;
   assign unit_count = opnd_q[SC_W-1:0];

   p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (micro_q == $past(micro_q)));

endmodule

// File: tb/sim_eae_sequencer.sv
module sim_eae_sequencer;

   localparam int DW = 12;
   localparam int SW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          instr_valid = 1'b0;
   logic [DW-1:0] instr_word = '0;
   logic          busy, seq_done;
   logic          cpu_ac_we = 1'b0;
   logic [DW-1:0] cpu_ac_wdata = '0;
   logic          cpu_link_we = 1'b0;
   logic          cpu_link_wdata = 1'b0;
   logic          opnd_req;
   logic          opnd_valid = 1'b0;
   logic [DW-1:0] opnd_data = '0;
   logic          unit_start;
   logic [2:0]    unit_cmd;
   logic [DW-1:0] unit_arg;
   logic [SW-1:0] unit_count;
   logic          unit_done = 1'b0;
   logic [DW-1:0] unit_res_ac = '0;
   logic [DW-1:0] unit_res_mq = '0;
   logic          unit_res_link = 1'b0;
   logic [SW-1:0] unit_res_sc = '0;
   logic [DW-1:0] ac, mq;
   logic          link;
   logic [SW-1:0] sc;

   eae_sequencer #(.DATA_W(DW), .SC_W(SW), .SPLIT_PHASES(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .instr_valid(instr_valid), .instr_word(instr_word),
      .busy(busy), .seq_done(seq_done),
      .cpu_ac_we(cpu_ac_we), .cpu_ac_wdata(cpu_ac_wdata),
      .cpu_link_we(cpu_link_we), .cpu_link_wdata(cpu_link_wdata),
      .opnd_req(opnd_req), .opnd_valid(opnd_valid), .opnd_data(opnd_data),
      .unit_start(unit_start), .unit_cmd(unit_cmd), .unit_arg(unit_arg),
      .unit_count(unit_count), .unit_done(unit_done),
      .unit_res_ac(unit_res_ac), .unit_res_mq(unit_res_mq),
      .unit_res_link(unit_res_link), .unit_res_sc(unit_res_sc),
      .ac(ac), .mq(mq), .link(link), .sc(sc)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- operand source ----------------
   int            opnd_delay = 0;
   logic [DW-1:0] opnd_val = '0;
   int            fetches = 0;
   int            req_cycles = 0;
   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (opnd_req) req_cycles++;
         if (opnd_req && !opnd_valid) begin
            if (cnt >= opnd_delay) begin
               opnd_valid = 1'b1;
               opnd_data  = opnd_val;
               fetches++;
            end else cnt++;
         end else begin
            opnd_valid = 1'b0;
            cnt = 0;
         end
      end
   end

   // ---------------- arithmetic / shift unit model ----------------
   int            unit_delay = 2;
   int            starts = 0;
   int            dones = 0;
   logic [2:0]    last_cmd = '0;
   logic [DW-1:0] last_arg = '0;
   logic [SW-1:0] last_cnt = '0;
   initial begin
      int cd;
      logic [2*DW-1:0] prod;
      cd = -1;
      forever begin
         @(negedge clk);
         if (seq_done) dones++;
         if (unit_done) unit_done = 1'b0;
         if (unit_start) begin
            starts++;
            last_cmd = unit_cmd;
            last_arg = unit_arg;
            last_cnt = unit_count;
            case (unit_cmd)
               3'd2: begin
                  prod = mq * unit_arg;
                  unit_res_ac = prod[2*DW-1:DW];
                  unit_res_mq = prod[DW-1:0];
                  unit_res_link = 1'b0;
                  unit_res_sc = '0;
               end
               3'd4: begin
                  unit_res_ac = ~ac;
                  unit_res_mq = mq + 1'b1;
                  unit_res_link = ~link;
                  unit_res_sc = 5'd9;
               end
               default: begin
                  unit_res_ac = ac ^ unit_arg;
                  unit_res_mq = mq + 1'b1;
                  unit_res_link = ~link;
                  unit_res_sc = 5'd9;
               end
            endcase
            cd = unit_delay;
         end else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               unit_done = 1'b1;
               cd = -1;
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic issue(input logic [DW-1:0] w);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = w;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t;
      t = 0;
      while (!seq_done && t < 300) begin
         @(negedge clk);
         t++;
      end
      if (!seq_done) chk(req, 32'd0, 32'd1);
   endtask

   task automatic run(input logic [DW-1:0] w, input logic [DW-1:0] op_word);
      opnd_val = op_word;
      issue(w);
      wait_done("R12 done timeout");
   endtask

   task automatic cpu_write(input logic [DW-1:0] a, input logic l);
      @(negedge clk);
      cpu_ac_we = 1'b1; cpu_ac_wdata = a;
      cpu_link_we = 1'b1; cpu_link_wdata = l;
      @(negedge clk);
      cpu_ac_we = 1'b0; cpu_link_we = 1'b0;
   endtask

   task automatic setup(input logic [DW-1:0] a0, input logic [DW-1:0] m0,
                        input logic l0, input logic [DW-1:0] scop);
      run(12'o7403, scop);      // load step counter
      cpu_write(m0, 1'b0);
      run(12'o7421, '0);        // AC -> MQ
      cpu_write(a0, l0);
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic [DW-1:0] word;
      logic [DW-1:0] ac0;
      logic [DW-1:0] mq0;
      logic          l0;
      logic [DW-1:0] scop;
      logic [DW-1:0] opnd;
      logic [DW-1:0] eac;
      logic [DW-1:0] emq;
      logic          el;
      logic [SW-1:0] esc;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{12'o7601, 12'h5A5, 12'h0F0, 1'b1, 12'h01F, 12'h000, 12'h000, 12'h0F0, 1'b1, 5'h00}, // R3
      '{12'o7501, 12'h5A0, 12'h00F, 1'b0, 12'h000, 12'h000, 12'h5AF, 12'h00F, 1'b0, 5'h1F}, // R4
      '{12'o7441, 12'h860, 12'h123, 1'b0, 12'h00A, 12'h000, 12'h875, 12'h123, 1'b0, 5'h15}, // R4
      '{12'o7641, 12'hFFF, 12'h321, 1'b1, 12'h003, 12'h000, 12'h01C, 12'h321, 1'b1, 5'h1C}, // R6
      '{12'o7421, 12'hABC, 12'h111, 1'b0, 12'h01F, 12'h000, 12'h000, 12'hABC, 1'b0, 5'h00}, // R5
      '{12'o7521, 12'hABC, 12'h456, 1'b1, 12'h01F, 12'h000, 12'h456, 12'hABC, 1'b1, 5'h00}, // R5 swap
      '{12'o7403, 12'h777, 12'h222, 1'b0, 12'h000, 12'hFE4, 12'h777, 12'h222, 1'b0, 5'h1B}, // R9
      '{12'o7405, 12'h000, 12'h0C8, 1'b1, 12'h01F, 12'h064, 12'h004, 12'hE20, 1'b0, 5'h00}, // R10
      '{12'o7425, 12'h0FF, 12'h999, 1'b1, 12'h01E, 12'h002, 12'h000, 12'h1FE, 1'b0, 5'h01}, // R6
      '{12'o7411, 12'h0F0, 12'h010, 1'b0, 12'h01F, 12'h000, 12'hF0F, 12'h011, 1'b1, 5'h09}, // R11
      '{12'o7407, 12'h300, 12'h020, 1'b1, 12'h010, 12'h00F, 12'h30F, 12'h021, 1'b0, 5'h0F}, // R10
      '{12'o7607, 12'hFFF, 12'h001, 1'b0, 12'h01F, 12'h055, 12'h055, 12'h002, 1'b1, 5'h00}, // R6
      '{12'o7541, 12'h100, 12'h00A, 1'b0, 12'h01C, 12'h000, 12'h10B, 12'h00A, 1'b0, 5'h03}, // R4
      '{12'o7417, 12'h123, 12'h050, 1'b0, 12'h01F, 12'h00F, 12'h12C, 12'h051, 1'b1, 5'h00}  // R10
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ac", 32'(ac), 0);
      chk("R1 mq", 32'(mq), 0);
      chk("R1 link", 32'(link), 0);
      chk("R1 sc", 32'(sc), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 ctrl", {29'd0, seq_done, opnd_req, unit_start}, 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         int f0, s0;
         logic [2:0] op;
         op = VEC[i].word[3:1];
         opnd_delay = i % 3;
         setup(VEC[i].ac0, VEC[i].mq0, VEC[i].l0, VEC[i].scop);
         f0 = fetches; s0 = starts;
         run(VEC[i].word, VEC[i].opnd);
         chk($sformatf("R3-6 vec%0d ac", i), 32'(ac), 32'(VEC[i].eac));
         chk($sformatf("R5 vec%0d mq", i), 32'(mq), 32'(VEC[i].emq));
         chk($sformatf("R10 vec%0d link", i), 32'(link), 32'(VEC[i].el));
         chk($sformatf("R9 vec%0d sc", i), 32'(sc), 32'(VEC[i].esc));
         chk($sformatf("R8 vec%0d fetch count", i), 32'(fetches - f0),
             (op != 3'd0 && op != 3'd4) ? 1 : 0);
         chk($sformatf("R7 vec%0d start count", i), 32'(starts - s0),
             (op >= 3'd2) ? 1 : 0);
         if (op >= 3'd2) chk($sformatf("R10 vec%0d cmd", i), 32'(last_cmd), 32'(op));
      end
      // last vector was the logical right shift with operand 00F
      chk("R10 unit_arg", 32'(last_arg), 32'h00F);
      chk("R10 unit_count", 32'(last_cnt), 32'h0F);

      // R2 non-group words are ignored
      begin
         int d0, f0;
         cpu_write(12'h5A5, 1'b1);
         d0 = dones; f0 = fetches;
         issue(12'o7400);
         issue(12'o7001);
         issue(12'o7403);   // bits 0-3 ones, bit 11 one: accepted control below
         wait_done("R2 control word");
         repeat (4) @(negedge clk);
         chk("R2 done count", 32'(dones - d0), 1);
         chk("R2 ac kept", 32'(ac), 32'h5A5);
         chk("R2 link kept", 32'(link), 1);
         chk("R2 fetch count", 32'(fetches - f0), 1);
      end

      // R8 request held through a long operand delay
      begin
         int r0;
         opnd_delay = 4;
         r0 = req_cycles;
         run(12'o7403, 12'h01F);
         chk("R8 request cycles", 32'(req_cycles - r0), 5);
         chk("R9 sc after delayed load", 32'(sc), 0);
      end

      // R12 a word offered while busy is ignored
      begin
         int d0;
         opnd_delay = 0;
         unit_delay = 8;
         setup(12'h000, 12'h0C8, 1'b0, 12'h01F);
         d0 = dones;
         opnd_val = 12'h064;
         issue(12'o7405);
         repeat (3) @(negedge clk);
         chk("R12 busy during unit", 32'(busy), 1);
         issue(12'o7601);
         wait_done("R12 long multiply");
         repeat (6) @(negedge clk);
         chk("R12 single done", 32'(dones - d0), 1);
         chk("R12 ac product", 32'(ac), 32'h004);
         chk("R12 mq product", 32'(mq), 32'hE20);
         chk("R12 idle after", 32'(busy), 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule